// File: doc/BRIEF.md
# Configuration Access Router

This block sits between a host-side configuration request channel and two downstream paths of a bridge root port. A request carries a 32-bit tag holding bus, device and function numbers, a register offset, a read/write flag and write data. The router decodes the tag and drops requests aimed at targets that cannot exist. Requests for the root bus go straight to the local register space of the root complex. Requests for any other bus first reprogram a shared outbound translation window, then perform the access through that window.

Only device 0 exists on the root bus and on the bus directly below it, because both are reached with type 0 configuration cycles. The bus directly below the root is given type 0 and every deeper bus is given type 1. The window is shared, so the router handles one request at a time. It stalls new requests until the response for the current one has been returned. A side query port reports how many device slots a bus may hold, for use by enumeration logic.

Top module: `cfg_route_top`

## Requirements
- R1: The tag is decoded as bus = tag[27:20], device = tag[19:15] and function = tag[14:12]. Tag bits 31:28 and 11:0 are ignored.
- R2: A request whose offset is 4096 or greater is rejected. No local, window or remote strobe is raised for it. A rejected read responds with 0xFFFFFFFF.
- R3: A request with a non-zero device number on bus BUS_MIN or on bus BUS_MIN+1 is rejected in the same way as R2.
- R4: An accepted request on bus BUS_MIN raises one local access with loc_addr = device<<15 | function<<12 | offset[11:0], carrying the write flag and the write data. A local read responds with loc_rdata.
- R5: An accepted request on any other bus first raises a window write with win_sel=0 and data bus<<20 | 19. A second window write follows, with win_sel=1 and data bit 23 set plus type code 0xA when the bus is BUS_MIN+1, or 0xB otherwise. Both come before the remote access.
- R6: After the two window writes, one remote access is raised at rem_addr with the same 20-bit layout as R4, carrying the write flag and the write data. A remote read without error responds with rem_rdata.
- R7: A remote read completed with rem_err=1 responds with 0xFFFFFFFF instead of rem_rdata.
- R8: The router accepts a request only when req_ready=1. req_ready stays 0 from acceptance until the end of the one-cycle rsp_valid pulse, and each accepted request gets exactly one pulse. A write responds with rsp_rdata = 0.
- R9: qry_maxdev reports 1 for qry_bus equal to BUS_MIN or BUS_MIN+1 and 32 for every other bus.
- R10: At most one of loc_valid, win_valid and rem_valid is high in any cycle. Each is held until its matching done input is seen.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router idle, request accepted on this cycle if valid |
| req_tag | input | 32 | Bus/device/function tag |
| req_off | input | 16 | Register offset in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read data, all-ones on reject or fault, zero for writes |
| loc_valid | output | 1 | Local register access strobe, held until loc_done |
| loc_write | output | 1 | Local access direction |
| loc_addr | output | 20 | Local register offset |
| loc_wdata | output | 32 | Local write data |
| loc_done | input | 1 | Local access complete |
| loc_rdata | input | 32 | Local read data, taken with loc_done |
| win_valid | output | 1 | Window register write strobe, held until win_done |
| win_sel | output | 1 | 0 = address word, 1 = descriptor word |
| win_data | output | 32 | Window register value |
| win_done | input | 1 | Window write complete |
| rem_valid | output | 1 | Remote access strobe, held until rem_done |
| rem_write | output | 1 | Remote access direction |
| rem_addr | output | 20 | Offset inside the translation window |
| rem_wdata | output | 32 | Remote write data |
| rem_done | input | 1 | Remote access complete |
| rem_rdata | input | 32 | Remote read data, taken with rem_done |
| rem_err | input | 1 | Remote access faulted, taken with rem_done |
| qry_bus | input | 8 | Bus number for the slot-count query |
| qry_maxdev | output | 6 | Device slots on qry_bus |

## Verification
The assertions assume each downstream done input only rises while its matching strobe is high and lasts one cycle. They also assume the requester holds its fields stable on the cycle it raises req_valid. The bench's responders answer only a strobe they see high, drop done on the following cycle, and drive a fault flag only with a remote done. Requests are issued only after the previous response pulse has ended, so the stall check watches req_ready while the downstream strobes are busy.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

   // Descriptor word fields the translation unit decodes
   localparam int unsigned DESC_RID_BIT = 23;
   localparam logic [3:0]  CFG_TYPE0    = 4'hA;
   localparam logic [3:0]  CFG_TYPE1    = 4'hB;

   typedef enum logic [1:0] {
      RT_REJECT = 2'd0,
      RT_LOCAL  = 2'd1,
      RT_REMOTE = 2'd2
   } route_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_LOC  = 3'd1,
      ST_WADR = 3'd2,
      ST_WDSC = 3'd3,
      ST_REM  = 3'd4,
      ST_RSP  = 3'd5
   } seq_state_e;

endpackage

// File: rtl/cfg_tag_decode.sv
module cfg_tag_decode
   import cfg_route_pkg::*;
#(
   parameter int TAG_W   = 32,
   parameter int BUS_W   = 8,
   parameter int DEV_W   = 5,
   parameter int FN_W    = 3,
   parameter int REG_W   = 12,
   parameter int OFF_W   = 16,
   parameter int BUS_MIN = 0,
   localparam int LADDR_W = DEV_W + FN_W + REG_W,
   localparam int BUS_LSB = LADDR_W
) (
   input  logic [TAG_W-1:0]   tag,
   input  logic [OFF_W-1:0]   off,
   output logic [BUS_W-1:0]   bus,
   output logic [LADDR_W-1:0] laddr,
   output route_e             route,
   output logic               type1
);

   localparam logic [BUS_W-1:0] BUS_ROOT = BUS_W'(BUS_MIN);
   localparam logic [BUS_W-1:0] BUS_NEXT = BUS_W'(BUS_MIN + 1);

   logic [DEV_W-1:0] dev;
   logic [FN_W-1:0]  fn;
   logic             off_big;
   logic             on_root;
   logic             on_next;
   logic             dev_bad;

   assign bus = tag[BUS_LSB +: BUS_W];
   assign dev = tag[REG_W + FN_W +: DEV_W];
   assign fn  = tag[REG_W +: FN_W];

   generate
      if (TAG_W > BUS_LSB + BUS_W) begin : g_hi_unused
         logic unused_tag_hi;
         assign unused_tag_hi = ^tag[TAG_W-1:BUS_LSB + BUS_W];
      end
   endgenerate

   logic unused_tag_lo;
   assign unused_tag_lo = ^tag[REG_W-1:0];

   // Offset range: only a wider offset field can overflow the register space
   generate
      if (OFF_W > REG_W) begin : g_off_wide
         assign off_big = |off[OFF_W-1:REG_W];
      end else begin : g_off_fit
         assign off_big = 1'b0;
      end
   endgenerate

   assign laddr   = {dev, fn, off[REG_W-1:0]};
   assign on_root = (bus == BUS_ROOT);
   assign on_next = (bus == BUS_NEXT);
   assign dev_bad = (dev != '0) && (on_root || on_next);
   assign type1   = !on_next;

   always_comb begin
      if (off_big || dev_bad) begin
         route = RT_REJECT;
      end else if (on_root) begin
         route = RT_LOCAL;
      end else begin
         route = RT_REMOTE;
      end
   end

endmodule

// File: rtl/cfg_maxdev.sv
module cfg_maxdev #(
   parameter int BUS_W   = 8,
   parameter int DEV_W   = 5,
   parameter int BUS_MIN = 0,
   localparam int CNT_W  = DEV_W + 1
) (
   input  logic [BUS_W-1:0] qry_bus,
   output logic [CNT_W-1:0] qry_maxdev
);

   localparam logic [BUS_W-1:0] BUS_ROOT = BUS_W'(BUS_MIN);
   localparam logic [BUS_W-1:0] BUS_NEXT = BUS_W'(BUS_MIN + 1);
   localparam logic [CNT_W-1:0] ALL_DEV  = CNT_W'(1) << DEV_W;
   localparam logic [CNT_W-1:0] ONE_DEV  = CNT_W'(1);

   always_comb begin
      if ((qry_bus == BUS_ROOT) || (qry_bus == BUS_NEXT)) begin
         qry_maxdev = ONE_DEV;
      end else begin
         qry_maxdev = ALL_DEV;
      end
   end

endmodule

// File: rtl/cfg_route_seq.sv
module cfg_route_seq
   import cfg_route_pkg::*;
#(
   parameter int BUS_W   = 8,
   parameter int DATA_W  = 32,
   parameter int LADDR_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [DATA_W-1:0]  req_wdata,
   input  route_e             dec_route,
   input  logic               dec_type1,
   input  logic [BUS_W-1:0]   dec_bus,
   input  logic [LADDR_W-1:0] dec_laddr,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic               loc_valid,
   output logic               loc_write,
   output logic [LADDR_W-1:0] loc_addr,
   output logic [DATA_W-1:0]  loc_wdata,
   input  logic               loc_done,
   input  logic [DATA_W-1:0]  loc_rdata,
   output logic               win_valid,
   output logic               win_sel,
   output logic [DATA_W-1:0]  win_data,
   input  logic               win_done,
   output logic               rem_valid,
   output logic               rem_write,
   output logic [LADDR_W-1:0] rem_addr,
   output logic [DATA_W-1:0]  rem_wdata,
   input  logic               rem_done,
   input  logic [DATA_W-1:0]  rem_rdata,
   input  logic               rem_err
);

   localparam logic [DATA_W-1:0] ALL_ONES  = '1;
   localparam logic [DATA_W-1:0] WIN_SPAN  = DATA_W'(LADDR_W - 1);
   localparam logic [DATA_W-1:0] RID_FLAG  = DATA_W'(1) << DESC_RID_BIT;

   seq_state_e             st_q, st_d;
   logic                   wr_q;
   logic [DATA_W-1:0]      wdata_q;
   logic [LADDR_W-1:0]     laddr_q;
   logic [BUS_W-1:0]       bus_q;
   logic                   type1_q;
   logic [DATA_W-1:0]      rdata_q;
   logic                   accept;
   logic [DATA_W-1:0]      win_word0;
   logic [DATA_W-1:0]      win_word1;

   assign accept = req_valid && req_ready;

   // Window words: bus number above the window span, then the descriptor
   assign win_word0 = (DATA_W'(bus_q) << LADDR_W) | WIN_SPAN;
   assign win_word1 = RID_FLAG | DATA_W'(type1_q ? CFG_TYPE1 : CFG_TYPE0);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (accept) begin
               unique case (dec_route)
                  RT_LOCAL:  st_d = ST_LOC;
                  RT_REMOTE: st_d = ST_WADR;
                  default:   st_d = ST_RSP;
               endcase
            end
         end
         ST_LOC:  if (loc_done) st_d = ST_RSP;
         ST_WADR: if (win_done) st_d = ST_WDSC;
         ST_WDSC: if (win_done) st_d = ST_REM;
         ST_REM:  if (rem_done) st_d = ST_RSP;
         ST_RSP:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         wr_q    <= 1'b0;
         wdata_q <= '0;
         laddr_q <= '0;
         bus_q   <= '0;
         type1_q <= 1'b0;
         rdata_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            laddr_q <= dec_laddr;
            bus_q   <= dec_bus;
            type1_q <= dec_type1;
            if (dec_route == RT_REJECT) begin
               rdata_q <= req_write ? '0 : ALL_ONES;
            end
         end
         if (st_q == ST_LOC && loc_done) begin
            rdata_q <= wr_q ? '0 : loc_rdata;
         end
         if (st_q == ST_REM && rem_done) begin
            if (wr_q) begin
               rdata_q <= '0;
            end else begin
               rdata_q <= rem_err ? ALL_ONES : rem_rdata;
            end
         end
      end
   end

   assign req_ready = (st_q == ST_IDLE);
   assign rsp_valid = (st_q == ST_RSP);
   assign rsp_rdata = rdata_q;

   assign loc_valid = (st_q == ST_LOC);
   assign loc_write = wr_q;
   assign loc_addr  = laddr_q;
   assign loc_wdata = wdata_q;

   assign win_valid = (st_q == ST_WADR) || (st_q == ST_WDSC);
   assign win_sel   = (st_q == ST_WDSC);
   assign win_data  = win_sel ? win_word1 : win_word0;

   assign rem_valid = (st_q == ST_REM);
   assign rem_write = wr_q;
   assign rem_addr  = laddr_q;
   assign rem_wdata = wdata_q;

endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
   import cfg_route_pkg::*;
#(
   parameter int TAG_W   = 32,
   parameter int BUS_W   = 8,
   parameter int DEV_W   = 5,
   parameter int FN_W    = 3,
   parameter int REG_W   = 12,
   parameter int OFF_W   = 16,
   parameter int DATA_W  = 32,
   parameter int BUS_MIN = 0,
   localparam int LADDR_W = DEV_W + FN_W + REG_W,
   localparam int CNT_W   = DEV_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [TAG_W-1:0]   req_tag,
   input  logic [OFF_W-1:0]   req_off,
   input  logic               req_write,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic               loc_valid,
   output logic               loc_write,
   output logic [LADDR_W-1:0] loc_addr,
   output logic [DATA_W-1:0]  loc_wdata,
   input  logic               loc_done,
   input  logic [DATA_W-1:0]  loc_rdata,
   output logic               win_valid,
   output logic               win_sel,
   output logic [DATA_W-1:0]  win_data,
   input  logic               win_done,
   output logic               rem_valid,
   output logic               rem_write,
   output logic [LADDR_W-1:0] rem_addr,
   output logic [DATA_W-1:0]  rem_wdata,
   input  logic               rem_done,
   input  logic [DATA_W-1:0]  rem_rdata,
   input  logic               rem_err,
   input  logic [BUS_W-1:0]   qry_bus,
   output logic [CNT_W-1:0]   qry_maxdev
);

   // Elaboration-time parameter checks
   generate
      if (TAG_W < LADDR_W + BUS_W) begin : g_bad_tag
         initial $fatal(1, "TAG_W too narrow for bus/device/function fields");
      end
      if (OFF_W < REG_W) begin : g_bad_off
         initial $fatal(1, "OFF_W must cover the register offset");
      end
      if (DATA_W < BUS_W + LADDR_W || DATA_W <= DESC_RID_BIT) begin : g_bad_data
         initial $fatal(1, "DATA_W too narrow for window words");
      end
      if (BUS_MIN < 0 || BUS_MIN >= (1 << BUS_W) - 1) begin : g_bad_min
         initial $fatal(1, "BUS_MIN must leave room for the next bus");
      end
   endgenerate

   logic [BUS_W-1:0]   dec_bus;
   logic [LADDR_W-1:0] dec_laddr;
   route_e             dec_route;
   logic               dec_type1;

   cfg_tag_decode #(
      .TAG_W(TAG_W), .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W),
      .REG_W(REG_W), .OFF_W(OFF_W), .BUS_MIN(BUS_MIN)
   ) u_dec (
      .tag(req_tag), .off(req_off), .bus(dec_bus), .laddr(dec_laddr),
      .route(dec_route), .type1(dec_type1)
   );

   cfg_route_seq #(
      .BUS_W(BUS_W), .DATA_W(DATA_W), .LADDR_W(LADDR_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_wdata(req_wdata),
      .dec_route(dec_route), .dec_type1(dec_type1),
      .dec_bus(dec_bus), .dec_laddr(dec_laddr),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .loc_valid(loc_valid), .loc_write(loc_write), .loc_addr(loc_addr),
      .loc_wdata(loc_wdata), .loc_done(loc_done), .loc_rdata(loc_rdata),
      .win_valid(win_valid), .win_sel(win_sel), .win_data(win_data),
      .win_done(win_done),
      .rem_valid(rem_valid), .rem_write(rem_write), .rem_addr(rem_addr),
      .rem_wdata(rem_wdata), .rem_done(rem_done), .rem_rdata(rem_rdata),
      .rem_err(rem_err)
   );

   cfg_maxdev #(
      .BUS_W(BUS_W), .DEV_W(DEV_W), .BUS_MIN(BUS_MIN)
   ) u_maxdev (
      .qry_bus(qry_bus), .qry_maxdev(qry_maxdev)
   );

endmodule

// File: rtl/cfg_route_chk.sv
module cfg_route_chk #(
   parameter int TAG_W   = 32,
   parameter int BUS_W   = 8,
   parameter int DEV_W   = 5,
   parameter int FN_W    = 3,
   parameter int REG_W   = 12,
   parameter int OFF_W   = 16,
   parameter int DATA_W  = 32,
   parameter int BUS_MIN = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [TAG_W-1:0]  req_tag,
   input logic [OFF_W-1:0]  req_off,
   input logic              req_write,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              loc_valid,
   input logic              win_valid,
   input logic              win_sel,
   input logic              win_done,
   input logic              rem_valid,
   input logic              rem_write,
   input logic              rem_done,
   input logic              rem_err,
   input logic [BUS_W-1:0]  qry_bus,
   input logic [DEV_W:0]    qry_maxdev
);

   localparam int BUS_LSB = DEV_W + FN_W + REG_W;

   logic [BUS_W-1:0] c_bus;
   logic [DEV_W-1:0] c_dev;
   logic             c_take;
   logic             c_off_big;
   logic             c_dev_bad;

   assign c_bus     = req_tag[BUS_LSB +: BUS_W];
   assign c_dev     = req_tag[REG_W + FN_W +: DEV_W];
   assign c_take    = req_valid && req_ready;
   assign c_off_big = (req_off >= OFF_W'(1 << REG_W));
   assign c_dev_bad = (c_dev != '0) &&
                      ((c_bus == BUS_W'(BUS_MIN)) || (c_bus == BUS_W'(BUS_MIN + 1)));

   assert_offset_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (c_take && c_off_big) |=> (rsp_valid && !loc_valid && !win_valid && !rem_valid));

   assert_offset_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (c_take && c_off_big && !req_write) |=> (rsp_rdata == '1));

   assert_device_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (c_take && c_dev_bad) |=> (rsp_valid && !loc_valid && !win_valid));

   assert_local_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loc_valid) |-> $past(c_take));

   assert_desc_before_remote_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rem_valid) |-> $past(win_valid && win_sel && win_done));

   assert_fault_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_valid && rem_done && rem_err && !rem_write) |=> (rsp_valid && rsp_rdata == '1));

   assert_busy_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      c_take |=> !req_ready);

   assert_resp_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!req_ready && !$past(rsp_valid)));

   assert_slot_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_maxdev == (DEV_W+1)'(1)) ||
      (qry_maxdev == (DEV_W+1)'(1 << DEV_W)));

   assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({loc_valid, win_valid, rem_valid}));

   assert_win_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && !win_done) |=> win_valid);

   logic unused_chk;
   assign unused_chk = ^qry_bus;

endmodule

bind cfg_route_top cfg_route_chk #(
   .TAG_W(TAG_W), .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W),
   .REG_W(REG_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .BUS_MIN(BUS_MIN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_tag(req_tag), .req_off(req_off), .req_write(req_write),
   .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
   .loc_valid(loc_valid), .win_valid(win_valid), .win_sel(win_sel),
   .win_done(win_done), .rem_valid(rem_valid), .rem_write(rem_write),
   .rem_done(rem_done), .rem_err(rem_err),
   .qry_bus(qry_bus), .qry_maxdev(qry_maxdev)
);

// File: tb/sim_cfg_route_top.sv
`timescale 1ns/1ps
module sim_cfg_route_top;

   localparam int NV = 10;

   typedef struct packed {
      logic [31:0] tag;
      logic [15:0] off;
      logic        wr;
      logic [31:0] wdata;
      logic [1:0]  route;   // 0 reject, 1 local, 2 remote type 0, 3 remote type 1
      logic [19:0] eaddr;
      logic [31:0] erdata;
   } vec_t;

   localparam vec_t VEC [NV] = '{
      '{32'h0000_0000, 16'h0000, 1'b0, 32'h0,         2'd1, 20'h00000, 32'hA5A0_0000},
      '{32'h0000_2000, 16'h0010, 1'b0, 32'h0,         2'd1, 20'h02010, 32'hA5A0_2010},
      '{32'h0001_8000, 16'h0000, 1'b0, 32'h0,         2'd0, 20'h00000, 32'hFFFF_FFFF},
      '{32'h0010_1000, 16'h0004, 1'b0, 32'h0,         2'd2, 20'h01004, 32'h3C30_1004},
      '{32'h0010_8000, 16'h0000, 1'b0, 32'h0,         2'd0, 20'h00000, 32'hFFFF_FFFF},
      '{32'hF022_F000, 16'h0FFC, 1'b0, 32'h0,         2'd3, 20'h2FFFC, 32'h3C32_FFFC},
      '{32'h0000_0000, 16'h1000, 1'b0, 32'h0,         2'd0, 20'h00000, 32'hFFFF_FFFF},
      '{32'h0FFF_8ABC, 16'h0100, 1'b1, 32'h1234_5678, 2'd3, 20'hF8100, 32'h0},
      '{32'h0000_0000, 16'h0040, 1'b1, 32'hCAFE_F00D, 2'd1, 20'h00040, 32'h0},
      '{32'h0011_0000, 16'h0008, 1'b1, 32'h5555_AAAA, 2'd0, 20'h00000, 32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_tag = '0;
   logic [15:0] req_off = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        loc_valid, loc_write;
   logic [19:0] loc_addr;
   logic [31:0] loc_wdata;
   logic        loc_done = 1'b0;
   logic [31:0] loc_rdata = '0;
   logic        win_valid, win_sel;
   logic [31:0] win_data;
   logic        win_done = 1'b0;
   logic        rem_valid, rem_write;
   logic [19:0] rem_addr;
   logic [31:0] rem_wdata;
   logic        rem_done = 1'b0;
   logic [31:0] rem_rdata = '0;
   logic        rem_err = 1'b0;
   logic [7:0]  qry_bus = '0;
   logic [5:0]  qry_maxdev;

   always #4 clk = ~clk;

   cfg_route_top u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_tag(req_tag), .req_off(req_off), .req_write(req_write),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .loc_valid(loc_valid), .loc_write(loc_write), .loc_addr(loc_addr),
      .loc_wdata(loc_wdata), .loc_done(loc_done), .loc_rdata(loc_rdata),
      .win_valid(win_valid), .win_sel(win_sel), .win_data(win_data),
      .win_done(win_done), .rem_valid(rem_valid), .rem_write(rem_write),
      .rem_addr(rem_addr), .rem_wdata(rem_wdata), .rem_done(rem_done),
      .rem_rdata(rem_rdata), .rem_err(rem_err),
      .qry_bus(qry_bus), .qry_maxdev(qry_maxdev)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit fault_mode = 1'b0;

   // Responder records
   int          loc_cnt = 0, win_cnt = 0, rem_cnt = 0;
   logic [19:0] loc_a, rem_a;
   logic        loc_w, rem_w;
   logic [31:0] loc_wd, rem_wd, win_w0, win_w1;
   logic        win_last_sel;
   logic        order_ok = 1'b1;
   int          stall_bad = 0;
   int          rsp_cnt = 0;

   always @(negedge clk) begin
      if (loc_valid && !loc_done) begin
         loc_done  <= 1'b1;
         loc_rdata <= {12'hA5A, loc_addr};
         loc_cnt++; loc_a = loc_addr; loc_w = loc_write; loc_wd = loc_wdata;
      end else begin
         loc_done <= 1'b0;
      end
      if (win_valid && !win_done) begin
         win_done <= 1'b1;
         win_cnt++;
         if (win_sel) win_w1 = win_data; else win_w0 = win_data;
         win_last_sel = win_sel;
      end else begin
         win_done <= 1'b0;
      end
      if (rem_valid && !rem_done) begin
         rem_done  <= 1'b1;
         rem_err   <= fault_mode;
         rem_rdata <= fault_mode ? 32'h0BAD_0000 : {12'h3C3, rem_addr};
         rem_cnt++; rem_a = rem_addr; rem_w = rem_write; rem_wd = rem_wdata;
         if (win_last_sel !== 1'b1) order_ok = 1'b0;
      end else begin
         rem_done <= 1'b0;
         rem_err  <= 1'b0;
      end
      if (rst_n && (loc_valid || win_valid || rem_valid || rsp_valid) && req_ready)
         stall_bad++;
      if (rst_n && rsp_valid) rsp_cnt++;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic run_req(input logic [31:0] tag, input logic [15:0] off,
                          input logic wr, input logic [31:0] wd,
                          output logic [31:0] rd, output bit seen);
      int n;
      @(negedge clk);
      req_tag = tag; req_off = off; req_write = wr; req_wdata = wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 50) begin
         @(negedge clk);
         n++;
      end
      seen = rsp_valid;
      rd = rsp_rdata;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      summary();
   end

   initial begin
      logic [31:0] rd;
      bit seen;
      int l0, w0, r0, p0;
      logic [7:0] bus;

      repeat (3) @(negedge clk);
      // Reset state
      check("R8 reset req_ready", {31'b0, req_ready}, 32'd1);
      check("R10 reset strobes", {29'b0, loc_valid, win_valid, rem_valid}, 32'd0);
      check("R8 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         l0 = loc_cnt; w0 = win_cnt; r0 = rem_cnt; p0 = rsp_cnt;
         run_req(VEC[i].tag, VEC[i].off, VEC[i].wr, VEC[i].wdata, rd, seen);
         check("R8 response seen", {31'b0, seen}, 32'd1);
         check("R4 R6 R2 R3 response data", rd, VEC[i].erdata);
         @(negedge clk);
         check("R8 one response pulse", rsp_cnt - p0, 32'd1);
         bus = VEC[i].tag[27:20];
         case (VEC[i].route)
            2'd0: begin
               check("R2 R3 no strobes", (loc_cnt - l0) + (win_cnt - w0) + (rem_cnt - r0), 32'd0);
            end
            2'd1: begin
               check("R4 local count", loc_cnt - l0, 32'd1);
               check("R4 no window", win_cnt - w0, 32'd0);
               check("R4 R1 local addr", {12'b0, loc_a}, {12'b0, VEC[i].eaddr});
               check("R4 local write flag", {31'b0, loc_w}, {31'b0, VEC[i].wr});
               if (VEC[i].wr) check("R4 local wdata", loc_wd, VEC[i].wdata);
            end
            default: begin
               check("R5 window count", win_cnt - w0, 32'd2);
               check("R6 remote count", rem_cnt - r0, 32'd1);
               check("R5 R1 address word", win_w0, {4'h0, bus, 20'h00013});
               check("R5 descriptor", win_w1,
                     (VEC[i].route == 2'd2) ? 32'h0080_000A : 32'h0080_000B);
               check("R6 R1 remote addr", {12'b0, rem_a}, {12'b0, VEC[i].eaddr});
               check("R6 remote write flag", {31'b0, rem_w}, {31'b0, VEC[i].wr});
               if (VEC[i].wr) check("R6 remote wdata", rem_wd, VEC[i].wdata);
            end
         endcase
      end

      // Remote read fault returns all ones
      fault_mode = 1'b1;
      run_req(32'h0030_0000, 16'h0000, 1'b0, 32'h0, rd, seen);
      check("R7 faulted read", rd, 32'hFFFF_FFFF);
      // Faulted remote write still answers zero
      run_req(32'h0030_0000, 16'h0004, 1'b1, 32'h7, rd, seen);
      check("R8 faulted write response", rd, 32'h0);
      fault_mode = 1'b0;

      // Offset just under and just over the limit on a deep bus
      l0 = rem_cnt;
      run_req(32'h0040_0000, 16'h0FFF, 1'b0, 32'h0, rd, seen);
      check("R2 offset 4095 accepted", rd, 32'h3C30_0FFF);
      run_req(32'h0040_0000, 16'hFFFF, 1'b0, 32'h0, rd, seen);
      check("R2 offset 65535 rejected", rd, 32'hFFFF_FFFF);
      check("R2 only one remote strobe", rem_cnt - l0, 32'd1);

      // Slot count query
      qry_bus = 8'd0; #1;
      check("R9 root bus slots", {26'b0, qry_maxdev}, 32'd1);
      qry_bus = 8'd1; #1;
      check("R9 next bus slots", {26'b0, qry_maxdev}, 32'd1);
      qry_bus = 8'd2; #1;
      check("R9 deep bus slots", {26'b0, qry_maxdev}, 32'd32);
      qry_bus = 8'd255; #1;
      check("R9 last bus slots", {26'b0, qry_maxdev}, 32'd32);

      check("R8 stall while busy", stall_bad, 32'd0);
      check("R5 descriptor before remote", {31'b0, order_ok}, 32'd1);
      summary();
   end

endmodule